// File: doc/BRIEF.md
# Load/Store Alignment Guard

This block sits between the load/store unit and the bus. Every request it sees carries an address, an access size and a code for the instruction family that issued it. In the same cycle the block decides whether the address is misaligned for that size. It then either grants the request or refuses it as a usage fault. A misaligned access is allowed through only when the instruction family is one that may perform unaligned word or halfword accesses and the global trap-every-unaligned control is clear. Every other misaligned access is refused.

A refused request produces a one-cycle fault pulse on the next clock edge. The first such fault latches its address and size into a status holder. That status stays put until the clear input is asserted. A further fault that arrives while the status is still held sets a sticky overrun bit instead of overwriting the status.

The status holder is a three-state machine:
- `ST_EMPTY` means no status is held.
- `ST_HELD` means one fault is recorded.
- `ST_OVERRUN` means a later fault arrived while one was already recorded.

Its transitions are:
- `T_CAPTURE` (`ST_EMPTY`→`ST_HELD`) happens on a fault.
- `T_SPILL` (`ST_HELD`→`ST_OVERRUN`) happens on a fault without clear.
- `T_RELEASE` (`ST_HELD`/`ST_OVERRUN`→`ST_EMPTY`) happens on clear without a fault.
- `T_RECAPTURE` (any state →`ST_HELD`) happens on clear together with a fault, which records the new fault.

Top module: `access_align_guard`

Encodings used throughout:
- `req_size`: 0 byte, 1 halfword, 2 word, 3 dual word, 4 multiple word. Codes 5 to 7 are checked like a word access.
- `req_cls`: 0 general, 1 word-unaligned-capable family, 2 halfword-unaligned-capable family (covers the plain, unprivileged, signed and store variants), 3 general.

## Requirements
- R1: A byte access (`req_size`=0) is never flagged misaligned and is always granted.
- R2: A halfword access (`req_size`=1) is misaligned exactly when address bit 0 is 1.
- R3: Word, dual-word and multiple-word accesses (`req_size` 2, 3, 4, and codes 5–7) are misaligned exactly when address bits [1:0] are not 00.
- R4: An aligned request is granted in the cycle it is presented, whatever `req_cls` and `trap_all` are, and raises no fault.
- R5: With `trap_all`=0, a misaligned request is granted without a fault when `req_cls`=1 with `req_size`=2, or when `req_cls`=2 with `req_size`=1.
- R6: Any other misaligned request is not granted. `fault_pulse` is 1 for exactly the cycle after it. This covers class 0/3, a class whose size does not match, and every dual- or multiple-word access.
- R7: With `trap_all`=1, every misaligned request faults, including those from classes 1 and 2.
- R8: A fault while `ST_EMPTY` sets `flt_valid` and loads `flt_addr`/`flt_size` with the request's address and size on the next edge.
- R9: A fault while a status is held and without `clr` leaves `flt_addr`/`flt_size` unchanged and sets `flt_overrun`, which stays set.
- R10: `clr` without a fault clears `flt_valid` and `flt_overrun` on the next edge. `clr` together with a fault records the new fault with `flt_overrun`=0.
- R11: With `req_valid`=0, `grant`, `misaligned` and the next cycle's `fault_pulse` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_addr | input | ADDR_W | Request address |
| req_size | input | 3 | Access size code |
| req_cls | input | 2 | Instruction family code |
| trap_all | input | 1 | Fault on every misaligned access |
| clr | input | 1 | Clear held fault status |
| grant | output | 1 | Request may proceed to the bus (same cycle) |
| misaligned | output | 1 | Request address is misaligned for its size (same cycle) |
| fault_pulse | output | 1 | One-cycle usage fault, cycle after the request |
| flt_valid | output | 1 | A fault status is held |
| flt_overrun | output | 1 | Sticky: a further fault arrived while status was held |
| flt_addr | output | ADDR_W | Latched faulting address |
| flt_size | output | 3 | Latched faulting size code |

## Verification
The bench builds the block with the default `ADDR_W` of 32. This lets wide addresses with set upper bits pass through to `flt_addr` unchanged, so truncation of the captured address becomes visible. The bench sweeps every low-bit pattern against each size. It crosses each misaligned case with both permitted families, the mismatched family/size pairs and both `trap_all` values. The sequences drive the status machine through capture, spill, release and recapture, including a clear that lands in the same cycle as a fault.

// File: rtl/align_pkg.sv
package align_pkg;

    localparam int SIZE_W = 3;
    localparam int CLS_W  = 2;

    typedef enum logic [SIZE_W-1:0] {
        SZ_BYTE  = 3'd0,
        SZ_HALF  = 3'd1,
        SZ_WORD  = 3'd2,
        SZ_DUAL  = 3'd3,
        SZ_MULTI = 3'd4
    } acc_size_e;

    typedef enum logic [CLS_W-1:0] {
        CLS_GENERAL  = 2'd0,
        CLS_WORD_UNA = 2'd1,
        CLS_HALF_UNA = 2'd2,
        CLS_GENERAL2 = 2'd3
    } acc_cls_e;

    typedef enum logic [1:0] {
        ST_EMPTY   = 2'd0,
        ST_HELD    = 2'd1,
        ST_OVERRUN = 2'd2
    } flt_state_e;

endpackage

// File: rtl/align_detect.sv
module align_detect
    import align_pkg::*;
(
    input  logic [SIZE_W-1:0] size,
    input  logic [1:0]        addr_lo,
    output logic              mis
);
    always_comb begin
        unique case (size)
            SZ_BYTE: mis = 1'b0;
            SZ_HALF: mis = addr_lo[0];
            default: mis = |addr_lo;
        endcase
    end
endmodule

// File: rtl/align_policy.sv
module align_policy
    import align_pkg::*;
(
    input  logic              mis,
    input  logic [SIZE_W-1:0] size,
    input  logic [CLS_W-1:0]  cls,
    input  logic              trap_all,
    output logic              fault
);
    logic tolerant;

    always_comb begin
        unique case (cls)
            CLS_WORD_UNA: tolerant = (size == SZ_WORD);
            CLS_HALF_UNA: tolerant = (size == SZ_HALF);
            default:      tolerant = 1'b0;
        endcase
        fault = mis && (trap_all || !tolerant);
    end
endmodule

// File: rtl/fault_status.sv
module fault_status
    import align_pkg::*;
#(
    parameter int ADDR_W = 32
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit,
    input  logic              clr,
    input  logic [ADDR_W-1:0] hit_addr,
    input  logic [SIZE_W-1:0] hit_size,
    output logic              pulse,
    output logic              held,
    output logic              overrun,
    output logic [ADDR_W-1:0] addr_q,
    output logic [SIZE_W-1:0] size_q
);
    flt_state_e state_q, state_d;
    logic       load;

    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        unique case (state_q)
            ST_EMPTY: begin
                if (hit) begin
                    state_d = ST_HELD;       // T_CAPTURE
                    load    = 1'b1;
                end
            end
            ST_HELD: begin
                if (hit && clr) begin
                    state_d = ST_HELD;       // T_RECAPTURE
                    load    = 1'b1;
                end else if (hit) begin
                    state_d = ST_OVERRUN;    // T_SPILL
                end else if (clr) begin
                    state_d = ST_EMPTY;      // T_RELEASE
                end
            end
            ST_OVERRUN: begin
                if (hit && clr) begin
                    state_d = ST_HELD;       // T_RECAPTURE
                    load    = 1'b1;
                end else if (clr) begin
                    state_d = ST_EMPTY;      // T_RELEASE
                end
            end
            default: state_d = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse  <= 1'b0;
            addr_q <= '0;
            size_q <= '0;
        end else begin
            pulse <= hit;
            if (load) begin
                addr_q <= hit_addr;
                size_q <= hit_size;
            end
        end
    end

    always_comb begin
        held    = (state_q != ST_EMPTY);
        overrun = (state_q == ST_OVERRUN);
    end
endmodule

// File: rtl/access_align_guard.sv
module access_align_guard
    import align_pkg::*;
#(
    parameter int ADDR_W = 32
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [2:0]        req_size,
    input  logic [1:0]        req_cls,
    input  logic              trap_all,
    input  logic              clr,
    output logic              grant,
    output logic              misaligned,
    output logic              fault_pulse,
    output logic              flt_valid,
    output logic              flt_overrun,
    output logic [ADDR_W-1:0] flt_addr,
    output logic [2:0]        flt_size
);
    logic mis_raw;
    logic fault_raw;
    logic fault_now;

    align_detect u_detect (
        .size    (req_size),
        .addr_lo (req_addr[1:0]),
        .mis     (mis_raw)
    );

    align_policy u_policy (
        .mis      (mis_raw),
        .size     (req_size),
        .cls      (req_cls),
        .trap_all (trap_all),
        .fault    (fault_raw)
    );

    always_comb begin
        fault_now  = req_valid && fault_raw;
        misaligned = req_valid && mis_raw;
        grant      = req_valid && !fault_raw;
    end

    fault_status #(.ADDR_W(ADDR_W)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit      (fault_now),
        .clr      (clr),
        .hit_addr (req_addr),
        .hit_size (req_size),
        .pulse    (fault_pulse),
        .held     (flt_valid),
        .overrun  (flt_overrun),
        .addr_q   (flt_addr),
        .size_q   (flt_size)
    );
endmodule

// File: rtl/align_guard_chk.sv
module align_guard_chk #(
    parameter int ADDR_W = 32
)(
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_addr,
    input logic [2:0]        req_size,
    input logic [1:0]        req_cls,
    input logic              trap_all,
    input logic              clr,
    input logic              grant,
    input logic              misaligned,
    input logic              fault_pulse,
    input logic              flt_valid,
    input logic              flt_overrun,
    input logic [ADDR_W-1:0] flt_addr,
    input logic [2:0]        flt_size
);
    a_r1_byte_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_size == 3'd0) |-> (!misaligned && grant));

    a_r4_aligned_granted: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !misaligned) |-> grant);

    a_r6_refused_faults: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !grant) |=> fault_pulse);

    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> (!grant && !misaligned));

    a_r11_no_spurious_fault: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !grant) |=> !fault_pulse);

    a_r8_pulse_sets_valid: assert property (@(posedge clk) disable iff (!rst_n)
        fault_pulse |-> flt_valid);

    a_r9_held_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_valid && !clr) |=> ($stable(flt_addr) && $stable(flt_size) && flt_valid));

    a_r9_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_overrun && !clr) |=> flt_overrun);

    a_r10_release: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !(req_valid && !grant)) |=> (!flt_valid && !flt_overrun));
endmodule

bind access_align_guard align_guard_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_access_align_guard.sv
module sim_access_align_guard;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [2:0]    req_size = '0;
    logic [1:0]    req_cls = '0;
    logic          trap_all = 1'b0;
    logic          clr = 1'b0;
    logic          grant, misaligned, fault_pulse, flt_valid, flt_overrun;
    logic [AW-1:0] flt_addr;
    logic [2:0]    flt_size;

    always #2 clk = ~clk;

    access_align_guard #(.ADDR_W(AW)) u0 (.*);

    typedef struct {
        logic          g;
        logic          m;
        logic          f;
        logic          v;
        logic          o;
        logic [AW-1:0] a;
        logic [2:0]    s;
        string         tag;
    } exp_t;

    exp_t q[$];
    int   n_chk = 0;
    int   n_bad = 0;
    bit   done = 0;

    logic          m_v = 0, m_o = 0;
    logic [AW-1:0] m_a = '0;
    logic [2:0]    m_s = '0;

    function automatic logic want_mis(logic [2:0] s, logic [AW-1:0] a);
        if (s == 3'd0) return 1'b0;
        if (s == 3'd1) return a[0];
        return a[1:0] != 2'b00;
    endfunction

    function automatic logic tolerated(logic [1:0] c, logic [2:0] s);
        return (c == 2'd1 && s == 3'd2) || (c == 2'd2 && s == 3'd1);
    endfunction

    task automatic drive(input logic v, input logic [AW-1:0] a, input logic [2:0] s,
                         input logic [1:0] c, input logic t, input logic k, input string tag);
        exp_t e;
        logic mis, flt;
        @(negedge clk);
        req_valid = v; req_addr = a; req_size = s; req_cls = c; trap_all = t; clr = k;
        mis = v && want_mis(s, a);
        flt = mis && (t || !tolerated(c, s));
        if (flt) begin
            if (k || !m_v) begin m_v = 1; m_o = 0; m_a = a; m_s = s; end
            else m_o = 1;
        end else if (k) begin
            m_v = 0; m_o = 0;
        end
        e.g = v && !flt; e.m = mis; e.f = flt;
        e.v = m_v; e.o = m_o; e.a = m_a; e.s = m_s; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic cmp(input string tag, input string what, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    initial begin : monitor
        wait (rst_n);
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                n_chk++;
                cmp(e.tag, "grant", AW'(grant), AW'(e.g));
                cmp(e.tag, "misaligned", AW'(misaligned), AW'(e.m));
                cmp(e.tag, "fault_pulse", AW'(fault_pulse), AW'(e.f));
                cmp(e.tag, "flt_valid", AW'(flt_valid), AW'(e.v));
                cmp(e.tag, "flt_overrun", AW'(flt_overrun), AW'(e.o));
                if (e.v) begin
                    cmp(e.tag, "flt_addr", flt_addr, e.a);
                    cmp(e.tag, "flt_size", AW'(flt_size), AW'(e.s));
                end
            end
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : driver
        repeat (3) @(posedge clk);
        #1;
        n_chk++;
        if (grant !== 0 || fault_pulse !== 0 || flt_valid !== 0 || flt_overrun !== 0) begin
            n_bad++;
            $display("FAIL reset actual=%b%b%b%b expected=0000", grant, fault_pulse, flt_valid, flt_overrun);
        end
        @(negedge clk); rst_n = 1;

        drive(1, 32'hA5A5_1003, 3'd0, 2'd0, 0, 0, "R1 byte odd");
        drive(1, 32'hA5A5_1001, 3'd0, 2'd3, 1, 0, "R1 byte trap");
        drive(1, 32'h0000_2002, 3'd1, 2'd0, 0, 0, "R2 half even");
        drive(0, 32'h0, 3'd0, 2'd0, 0, 0, "R11 idle");
        drive(1, 32'hF000_2001, 3'd1, 2'd0, 0, 0, "R2 R6 R8 half odd general");
        drive(0, 32'h0, 3'd0, 2'd0, 0, 0, "R6 one-cycle pulse");
        drive(1, 32'h0000_3000, 3'd2, 2'd0, 1, 0, "R4 word aligned trap");
        drive(1, 32'h0000_3002, 3'd2, 2'd1, 0, 0, "R5 word class tolerated");
        drive(1, 32'h0000_4003, 3'd1, 2'd2, 0, 0, "R5 half class tolerated");
        drive(1, 32'h0000_4001, 3'd2, 2'd2, 0, 0, "R6 R9 size mismatch spill");
        drive(1, 32'h0000_4002, 3'd1, 2'd1, 0, 0, "R6 R9 mismatch again");
        drive(0, 32'hFFFF_FFFF, 3'd1, 2'd0, 0, 0, "R11 idle odd addr");
        drive(0, 32'h0, 3'd0, 2'd0, 0, 1, "R10 release");
        drive(0, 32'h0, 3'd0, 2'd0, 0, 0, "R10 stays empty");
        drive(1, 32'h0000_5004, 3'd3, 2'd1, 0, 0, "R3 dual aligned");
        drive(1, 32'h8000_5006, 3'd3, 2'd1, 0, 0, "R3 R6 dual misaligned");
        drive(1, 32'h0000_6008, 3'd4, 2'd0, 1, 0, "R3 R4 multi aligned");
        drive(1, 32'h1234_6002, 3'd4, 2'd1, 0, 1, "R10 recapture");
        drive(1, 32'h0000_6001, 3'd4, 2'd2, 0, 0, "R9 spill after recapture");
        drive(0, 32'h0, 3'd0, 2'd0, 0, 1, "R10 clear overrun");
        drive(1, 32'h0000_7003, 3'd2, 2'd1, 1, 0, "R7 word class trapped");
        drive(1, 32'h0000_7001, 3'd1, 2'd2, 1, 0, "R7 R9 half class trapped");
        drive(0, 32'h0, 3'd0, 2'd0, 0, 1, "R10 clear");
        for (int s = 0; s < 8; s++) begin
            for (int lo = 0; lo < 4; lo++) begin
                drive(1, 32'hC0DE_0100 | 32'(lo), 3'(s), 2'(lo), 1'(s & 1), 1'(lo == 3),
                      "R1 R2 R3 sweep");
            end
        end
        drive(0, 32'h0, 3'd0, 2'd0, 0, 0, "R11 tail");
        repeat (3) @(posedge clk);
        #2;
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule